// File: doc/BRIEF.md
# Indirect CSR Window Access Checker

This block decides whether an instruction that touches the indirect CSR window may go ahead. The window holds a supervisor select register, its alias registers, their virtual-supervisor counterparts and machine-level aliases. For each request it returns one of three results, one clock later: allow, illegal-instruction exception or virtual-instruction exception. The inputs are the 12-bit CSR address, the hart's privilege level, the virtualization flag, whether state-enable gating is implemented, and the machine and hypervisor state-enable-0 register values.

The block holds one select register shared by the window. It also holds a lookup, chosen by parameters, of which select values map to an implemented proxy register. The proxied registers themselves, the read and write data path and trap entry are handled elsewhere. If the parameter `HAS_IND` is 0, the indirect feature is absent from the hypervisor state-enable mask, and its enable bit there is treated as clear.

Top module: `csrind_access_gate`

## Requirements
- R1: Address bits [9:8] give the target level: 1 is supervisor, 2 is virtual-supervisor, 3 is machine alias. Address bits [2:0] equal to 0 mark a select register, and any other value marks an alias register.
- R2: When gating is implemented, the hart is not in M-mode and the target level is below 3, a clear bit 60 of the machine state-enable-0 input gives illegal-instruction.
- R3: When gating is implemented, V=1, the hart is not in M-mode, the target level is below 3 and the machine bit 60 is set, a clear bit 60 of the hypervisor state-enable-0 input gives virtual-instruction.
- R4: The state-enable results of R2 and R3 override every rule below them, even when those rules would give a different exception type.
- R5: With V=1, a non-M hart accessing any virtual-supervisor register (level 2) gets virtual-instruction.
- R6: With V=1 and the hart in user mode, an access to a supervisor-level register gets virtual-instruction.
- R7: An alias register access whose current select value has no implemented proxy gives illegal-instruction, for either value of V. Accesses to select registers skip this check.
- R8: A hart in M-mode, and any machine-alias address, bypass the state-enable checks.
- R9: When no earlier rule decides, a hart below the required level gets illegal-instruction. Levels 1 and 2 require S-mode and level 3 requires M-mode. Hart privilege is encoded 0=U, 1=S, 3=M.
- R10: The select register resets to 0 and is loaded by a write strobe. A write affects only requests issued in later cycles. Select values from `PROXY_BASE` (0x40) up to but not including `PROXY_BASE+PROXY_COUNT` (0x60) are implemented.
- R11: The result appears one cycle after the request, with `resp_valid` set. At most one exception output is high. All three outputs are 0 in a cycle that follows no request, and during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_wr_en | input | 1 | Load the select register |
| sel_wr_data | input | SEL_W | New select value |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 12 | CSR address of the access |
| hart_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| hart_virt | input | 1 | Virtualization flag |
| gate_impl | input | 1 | State-enable gating implemented |
| mstate0 | input | XLEN | Machine state-enable-0 value |
| hstate0 | input | XLEN | Hypervisor state-enable-0 value |
| resp_valid | output | 1 | Result valid |
| resp_illegal | output | 1 | Illegal-instruction result |
| resp_virtual | output | 1 | Virtual-instruction result |

## Verification
The select register is the only state whose error would reach a verdict. A stale or wrong select value shows up on the first alias access after a write, as an illegal result where allow was due or the reverse. That is why the bench writes the select register and then issues an alias request on the very next cycle. Rule-ordering errors leave no lasting state, but they show on the next response whose inputs meet two rules at once. The bench aims most of its directed cases at exactly those overlaps.

// File: rtl/csrind_pkg.sv
package csrind_pkg;
   typedef enum logic [1:0] {
      VD_ALLOW   = 2'd0,
      VD_ILLEGAL = 2'd1,
      VD_VIRTUAL = 2'd2
   } verdict_e;

   localparam logic [1:0] LVL_U = 2'd0;
   localparam logic [1:0] LVL_S = 2'd1;
   localparam logic [1:0] LVL_V = 2'd2;
   localparam logic [1:0] LVL_M = 2'd3;
endpackage

// File: rtl/csrind_sel_store.sv
module csrind_sel_store #(
   parameter int SEL_W       = 12,
   parameter int PROXY_BASE  = 'h40,
   parameter int PROXY_COUNT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_data,
   output logic             proxy_hit
);
   localparam int SEL_SPAN = 1 << SEL_W;
   localparam int LIM      = PROXY_BASE + PROXY_COUNT;

   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sel_q <= '0;
      else if (wr_en) sel_q <= wr_data;
   end

   generate
      if (PROXY_COUNT <= 0) begin : g_none
         assign proxy_hit = 1'b0;
      end else if (PROXY_BASE == 0 && PROXY_COUNT >= SEL_SPAN) begin : g_all
         assign proxy_hit = 1'b1;
      end else begin : g_range
         localparam logic [SEL_W:0] LO = (SEL_W+1)'(PROXY_BASE);
         localparam logic [SEL_W:0] HI = (SEL_W+1)'(LIM);
         logic [SEL_W:0] sel_ext;
         assign sel_ext   = {1'b0, sel_q};
         assign proxy_hit = (sel_ext >= LO) && (sel_ext < HI);
      end
   endgenerate
endmodule

// File: rtl/csrind_rule_eval.sv
module csrind_rule_eval
   import csrind_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int IND_BIT = 60,
   parameter bit HAS_IND = 1'b1
) (
   input  logic [11:0]     addr,
   input  logic [1:0]      priv,
   input  logic            virt,
   input  logic            gate,
   input  logic [XLEN-1:0] m_en,
   input  logic [XLEN-1:0] h_en,
   input  logic            proxy_hit,
   output verdict_e        verdict
);
   logic [1:0] lvl;
   logic       is_alias;
   logic       m_bit;
   logic       h_bit;
   logic       se_apply;
   logic [1:0] need;

   assign lvl      = addr[9:8];
   assign is_alias = (addr[2:0] != 3'd0);
   assign m_bit    = m_en[IND_BIT];
   assign need     = (lvl == LVL_M) ? LVL_M : LVL_S;
   assign se_apply = gate && (priv != LVL_M) && (lvl != LVL_M);

   generate
      if (HAS_IND) begin : g_hind
         assign h_bit = h_en[IND_BIT];
      end else begin : g_nohind
         logic unused_h;
         assign unused_h = h_en[IND_BIT];
         assign h_bit    = 1'b0;
      end
   endgenerate

   always_comb begin
      verdict = VD_ALLOW;
      if (se_apply && !m_bit)
         verdict = VD_ILLEGAL;
      else if (se_apply && virt && !h_bit)
         verdict = VD_VIRTUAL;
      else if (virt && (lvl != LVL_M) && ((lvl == LVL_V) || (priv == LVL_U)))
         verdict = VD_VIRTUAL;
      else if (is_alias && !proxy_hit)
         verdict = VD_ILLEGAL;
      else if (priv < need)
         verdict = VD_ILLEGAL;
   end
endmodule

// File: rtl/csrind_access_gate.sv
module csrind_access_gate
   import csrind_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int IND_BIT     = 60,
   parameter bit HAS_IND     = 1'b1,
   parameter int SEL_W       = 12,
   parameter int PROXY_BASE  = 'h40,
   parameter int PROXY_COUNT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr_en,
   input  logic [SEL_W-1:0] sel_wr_data,
   input  logic             req_valid,
   input  logic [11:0]      req_addr,
   input  logic [1:0]       hart_priv,
   input  logic             hart_virt,
   input  logic             gate_impl,
   input  logic [XLEN-1:0]  mstate0,
   input  logic [XLEN-1:0]  hstate0,
   output logic             resp_valid,
   output logic             resp_illegal,
   output logic             resp_virtual
);
   generate
      if (IND_BIT >= XLEN) begin : g_bad_bit
         $error("IND_BIT must lie inside XLEN");
      end
      if (PROXY_BASE + PROXY_COUNT > (1 << SEL_W)) begin : g_bad_range
         $error("proxy range exceeds select width");
      end
   endgenerate

   logic     proxy_hit;
   verdict_e verdict;

   csrind_sel_store #(
      .SEL_W(SEL_W), .PROXY_BASE(PROXY_BASE), .PROXY_COUNT(PROXY_COUNT)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .wr_en(sel_wr_en), .wr_data(sel_wr_data),
      .proxy_hit(proxy_hit)
   );

   csrind_rule_eval #(
      .XLEN(XLEN), .IND_BIT(IND_BIT), .HAS_IND(HAS_IND)
   ) u_eval (
      .addr(req_addr), .priv(hart_priv), .virt(hart_virt), .gate(gate_impl),
      .m_en(mstate0), .h_en(hstate0), .proxy_hit(proxy_hit), .verdict(verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid   <= 1'b0;
         resp_illegal <= 1'b0;
         resp_virtual <= 1'b0;
      end else begin
         resp_valid   <= req_valid;
         resp_illegal <= req_valid && (verdict == VD_ILLEGAL);
         resp_virtual <= req_valid && (verdict == VD_VIRTUAL);
      end
   end
endmodule

module csrind_access_gate_chk #(
   parameter int XLEN    = 64,
   parameter int IND_BIT = 60
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [11:0]     req_addr,
   input logic [1:0]      hart_priv,
   input logic            hart_virt,
   input logic            gate_impl,
   input logic [XLEN-1:0] mstate0,
   input logic            resp_valid,
   input logic            resp_illegal,
   input logic            resp_virtual
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R11
   one_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({resp_illegal, resp_virtual}));

   // R11
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (resp_valid == $past(req_valid)));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> (!resp_illegal && !resp_virtual));

   // R2
   m_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(req_valid && gate_impl && hart_priv != 2'd3 &&
                      req_addr[9:8] != 2'd3 && !mstate0[IND_BIT]))
      |-> resp_illegal);

   // R5
   vs_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(req_valid && hart_virt && hart_priv != 2'd3 &&
                      req_addr[9:8] == 2'd2 && (!gate_impl || mstate0[IND_BIT])))
      |-> resp_virtual);

   // R8
   m_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(req_valid && hart_priv == 2'd3 && !hart_virt))
      |-> !resp_virtual);
endmodule

bind csrind_access_gate csrind_access_gate_chk #(.XLEN(XLEN), .IND_BIT(IND_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .hart_priv(hart_priv), .hart_virt(hart_virt), .gate_impl(gate_impl),
   .mstate0(mstate0), .resp_valid(resp_valid), .resp_illegal(resp_illegal),
   .resp_virtual(resp_virtual)
);

// File: tb/tb_csrind_access_gate.sv
`timescale 1ns/1ps
module tb_csrind_access_gate;
   localparam int XLEN = 64;
   localparam int SEL_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel_wr_en = 1'b0;
   logic [SEL_W-1:0] sel_wr_data = '0;
   logic             req_valid = 1'b0;
   logic [11:0]      req_addr = '0;
   logic [1:0]       hart_priv = 2'd3;
   logic             hart_virt = 1'b0;
   logic             gate_impl = 1'b0;
   logic [XLEN-1:0]  mstate0 = '0;
   logic [XLEN-1:0]  hstate0 = '0;
   logic             resp_valid, resp_illegal, resp_virtual;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   csrind_access_gate dut (
      .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
      .req_valid(req_valid), .req_addr(req_addr), .hart_priv(hart_priv),
      .hart_virt(hart_virt), .gate_impl(gate_impl), .mstate0(mstate0),
      .hstate0(hstate0), .resp_valid(resp_valid), .resp_illegal(resp_illegal),
      .resp_virtual(resp_virtual)
   );

   // reference state
   int    ref_sel = 0;
   logic [2:0] exp_q [$];
   string      tag_q [$];

   // returns 0 allow, 1 illegal, 2 virtual
   function automatic int judge(int addr, int prv, bit v, bit g, bit mb, bit hb,
                                int sel, output string why);
      int  lvl = (addr >> 8) & 3;
      bit  alias_reg = (addr & 7) != 0;
      bit  in_win = (sel >= 'h40) && (sel < 'h60);
      int  need_lvl;
      if (g && prv != 3 && lvl != 3) begin
         if (!mb) begin why = "R2"; return 1; end
         if (v && !hb) begin why = "R3"; return 2; end
      end
      if (v && lvl == 2 && prv != 3) begin why = "R5"; return 2; end
      if (v && lvl == 1 && prv == 0) begin why = "R6"; return 2; end
      if (alias_reg && !in_win) begin why = "R7"; return 1; end
      need_lvl = (lvl == 3) ? 3 : 1;
      if (prv < need_lvl) begin why = "R9"; return 1; end
      why = "R1";
      return 0;
   endfunction

   task automatic compare_now();
      logic [2:0] e;
      string      t;
      if (exp_q.size() == 0) return;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if ({resp_valid, resp_illegal, resp_virtual} !== e) begin
         n_fail++;
         $display("FAIL %s: got v/i/x=%b expected %b", t,
                  {resp_valid, resp_illegal, resp_virtual}, e);
      end
   endtask

   // one cycle: check last result, then drive new inputs
   task automatic cyc(string tag, bit we, int wd, bit rv, int addr, int prv,
                      bit v, bit g, bit mb, bit hb);
      int    r;
      string why;
      logic [XLEN-1:0] mv, hv;
      @(negedge clk);
      compare_now();
      mv = {$urandom, $urandom};
      hv = {$urandom, $urandom};
      mv[60] = mb;
      hv[60] = hb;
      sel_wr_en   = we;
      sel_wr_data = SEL_W'(wd);
      req_valid   = rv;
      req_addr    = 12'(addr);
      hart_priv   = 2'(prv);
      hart_virt   = v;
      gate_impl   = g;
      mstate0     = mv;
      hstate0     = hv;
      r = judge(addr, prv, v, g, mb, hb, ref_sel, why);
      if (!rv) exp_q.push_back(3'b000);
      else     exp_q.push_back({1'b1, r == 1, r == 2});
      tag_q.push_back(tag == "" ? why : tag);
      if (we) ref_sel = wd;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_checks++;
      if ({resp_valid, resp_illegal, resp_virtual} !== 3'b000) begin
         n_fail++;
         $display("FAIL R11: reset outputs %b expected 000",
                  {resp_valid, resp_illegal, resp_virtual});
      end
      rst_n = 1'b1;

      // R10: select resets to 0, which is outside the proxy window
      cyc("R10", 0, 0, 1, 'h351, 3, 0, 0, 1, 1);
      // R10: write then use on the next cycle
      cyc("R10", 1, 'h45, 0, 0, 3, 0, 0, 1, 1);
      cyc("R10", 0, 0, 1, 'h351, 3, 0, 0, 1, 1);
      // R10: write and request in the same cycle sees the old value
      cyc("R10", 1, 'h60, 1, 'h351, 3, 0, 0, 1, 1);
      cyc("R10", 1, 'h5f, 1, 'h351, 3, 0, 0, 1, 1);
      cyc("R10", 0, 0, 1, 'h351, 3, 0, 0, 1, 1);
      // R8: M-mode ignores cleared enable bits
      cyc("R8", 0, 0, 1, 'h151, 3, 0, 1, 0, 0);
      // R8: machine alias from S skips state-enable, then base level
      cyc("R8", 0, 0, 1, 'h351, 1, 0, 1, 0, 0);
      // R2
      cyc("R2", 0, 0, 1, 'h150, 1, 0, 1, 0, 1);
      // R3
      cyc("R3", 0, 0, 1, 'h151, 1, 1, 1, 1, 0);
      // R4: illegal beats virtual-register rule
      cyc("R4", 0, 0, 1, 'h250, 0, 1, 1, 0, 1);
      // R4: virtual beats missing-proxy illegal
      cyc("R4", 1, 'h10, 0, 0, 1, 0, 0, 1, 1);
      cyc("R4", 0, 0, 1, 'h152, 1, 1, 1, 1, 0);
      // R5
      cyc("R5", 0, 0, 1, 'h251, 1, 1, 0, 0, 0);
      // R6
      cyc("R6", 0, 0, 1, 'h150, 0, 1, 0, 0, 0);
      // R7: missing proxy, both V values; select register unaffected
      cyc("R7", 0, 0, 1, 'h152, 1, 0, 0, 0, 0);
      cyc("R7", 0, 0, 1, 'h152, 1, 1, 0, 0, 0);
      cyc("R7", 0, 0, 1, 'h150, 1, 0, 0, 0, 0);
      // R1: offset 0 in the high group is a select register
      cyc("R1", 0, 0, 1, 'h158, 1, 0, 0, 0, 0);
      // R9
      cyc("R9", 0, 0, 1, 'h150, 0, 0, 0, 0, 0);
      cyc("R9", 1, 'h41, 0, 0, 1, 0, 0, 0, 0);
      cyc("R9", 0, 0, 1, 'h250, 1, 0, 0, 0, 0);
      cyc("R9", 0, 0, 1, 'h253, 1, 0, 0, 0, 0);
      // R11: idle cycle gives zeros
      cyc("R11", 0, 0, 0, 'h151, 1, 1, 1, 0, 0);

      for (int i = 0; i < 3000; i++) begin
         int prv_pick = $urandom_range(0, 2);
         int prv = (prv_pick == 2) ? 3 : prv_pick;
         bit v = (prv == 3) ? 1'b0 : 1'($urandom_range(0, 1));
         int addr = ($urandom_range(1, 3) << 8) | 'h50 | $urandom_range(0, 7);
         bit we = ($urandom_range(0, 7) == 0);
         cyc("", we, $urandom_range('h30, 'h70), 1'($urandom_range(0, 3) != 0),
             addr, prv, v, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0));
      end
      cyc("R11", 0, 0, 0, 0, 3, 0, 0, 1, 1);
      @(negedge clk);
      compare_now();

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule